// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps one private write-back cache coherent with its peers on a shared snooping bus. The cache is direct-mapped. Each line has a tag, a data word and a three-value coherence state: Invalid, Shared (clean and read-only) or Modified (the only copy, writable and dirty). The local processor issues reads and writes. The controller answers hits at once. For a miss, or for the first write to a clean line, it requests a bus transaction. When a fill conflicts with a dirty line, the controller first writes the dirty line back.

The controller also watches every transaction that other caches put on the bus. A remote read of a line held Modified makes the controller supply the dirty word and keep the line as Shared. A remote ownership request or invalidation removes the local copy, and a dirty copy is flushed first. No state is shared between caches. Each controller decides from its own copies only. A snoop is handled before the local request that is waiting. If a snoop invalidates a line whose upgrade is still waiting for the bus, that upgrade becomes a full ownership read.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and cpu_done, bus_req and snp_ack are low. The first read of any address therefore misses.
- R2: A read that misses (the line index is the low address bits, the tag is the rest) requests bus command 0 (read). The line fills as Shared and the fill word is returned. A later read of that address completes with no bus request.
- R3: A write that misses requests bus command 1 (read-for-ownership). After the grant the line holds the write data and is Modified.
- R4: A write that hits a Shared line requests bus command 2 (upgrade/invalidate). The line becomes Modified with the new data only when the grant arrives.
- R5: A write that hits a Modified line updates the data with no bus request.
- R6: A snooped read (snoop command 0) of a line held Modified responds with snp_flush high and the line data on snp_fdata. The line becomes Shared.
- R7: A snooped read of a line held Shared gives no flush, and the line stays Shared. A later local read hits.
- R8: A snooped read-for-ownership (command 1) or upgrade (command 2) of a line held Shared makes it Invalid. A later local read misses.
- R9: A snooped read-for-ownership of a line held Modified flushes its data and makes it Invalid.
- R10: A snoop whose tag does not match, or whose index holds an Invalid line, or a snooped write-back (command 3), changes nothing and gives no flush.
- R11: When a fill needs a line index that holds a Modified line, the controller first issues bus command 3 (write-back) with the old line's address and data, and then the fill request. A Shared victim is dropped without a write-back.
- R12: A snoop takes priority over a waiting local request. A snoop that invalidates a line with a waiting upgrade changes the waiting command to read-for-ownership.
- R13: Every cycle with snp_valid high is followed, one cycle later, by a single-cycle snp_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Local request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | TAG_W+IDX_W | Local address, index in the low bits |
| cpu_wdata | input | DATA_W | Local write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Line data after the operation |
| bus_req | output | 1 | Bus transaction pending |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_addr | output | TAG_W+IDX_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Transaction completes in this cycle |
| bus_rdata | input | DATA_W | Fill data, valid with bus_gnt |
| snp_valid | input | 1 | Remote transaction seen on the bus |
| snp_cmd | input | 2 | Remote command, same encoding as bus_cmd |
| snp_addr | input | TAG_W+IDX_W | Remote address |
| snp_ack | output | 1 | Snoop response valid |
| snp_flush | output | 1 | Local copy was dirty and is supplied |
| snp_fdata | output | DATA_W | Flushed data |

## Verification
The bench builds the controller with LINES=4, TAG_W=4 and DATA_W=16, so addresses are six bits wide. Two addresses that differ only in the tag share a line index. With these values a few addresses are enough to force dirty and clean evictions, and to make snoops that hit or miss on the tag. The fill word is derived from the requested address, so every miss and hit can be told apart by the returned data. The snoop that arrives while an upgrade is waiting for the bus is driven cycle by cycle, with the grant held back on purpose.

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_ack,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_fdata
);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;

  typedef enum logic [1:0] {F_IDLE, F_WB, F_REQ} fsm_t;
  fsm_t fsm;

  logic [1:0]        st [LINES];
  logic [TAG_W-1:0]  tg [LINES];
  logic [DATA_W-1:0] dt [LINES];
  logic [1:0]        cmd;
  logic [IDX_W-1:0]  ridx;
  logic [TAG_W-1:0]  rtag;
  logic [DATA_W-1:0] rwd;

  wire [IDX_W-1:0] cidx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] ctag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] sidx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] stag = snp_addr[ADDR_W-1:IDX_W];

  wire c_hit   = (st[cidx] != ST_I) && (tg[cidx] == ctag);
  wire s_hit   = snp_valid && (st[sidx] != ST_I) && (tg[sidx] == stag);
  wire s_kill  = s_hit && (snp_cmd == C_RDX || snp_cmd == C_UPG);
  wire s_share = s_hit && (snp_cmd == C_RD) && (st[sidx] == ST_M);
  wire s_flush = s_hit && (snp_cmd != C_WB) && (st[sidx] == ST_M);
  wire go      = !snp_valid;

  assign bus_req   = (fsm != F_IDLE);
  assign bus_cmd   = (fsm == F_WB) ? C_WB : cmd;
  assign bus_addr  = {(fsm == F_WB) ? tg[ridx] : rtag, ridx};
  assign bus_wdata = dt[ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st[i] <= ST_I;
        tg[i] <= '0;
        dt[i] <= '0;
      end
      fsm       <= F_IDLE;
      cmd       <= C_RD;
      ridx      <= '0;
      rtag      <= '0;
      rwd       <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      snp_ack   <= 1'b0;
      snp_flush <= 1'b0;
      snp_fdata <= '0;
    end else begin
      cpu_done  <= 1'b0;
      snp_ack   <= snp_valid;
      snp_flush <= s_flush;
      snp_fdata <= dt[sidx];
      if (s_kill) st[sidx] <= ST_I;
      else if (s_share) st[sidx] <= ST_S;

      case (fsm)
        F_IDLE: if (cpu_req && go) begin
          ridx <= cidx;
          rtag <= ctag;
          rwd  <= cpu_wdata;
          if (c_hit && !cpu_we) begin
            cpu_done  <= 1'b1;
            cpu_rdata <= dt[cidx];
          end else if (c_hit && st[cidx] == ST_M) begin
            dt[cidx]  <= cpu_wdata;
            cpu_done  <= 1'b1;
            cpu_rdata <= cpu_wdata;
          end else if (c_hit) begin
            cmd <= C_UPG;
            fsm <= F_REQ;
          end else begin
            cmd <= cpu_we ? C_RDX : C_RD;
            fsm <= (st[cidx] == ST_M) ? F_WB : F_REQ;
          end
        end
        F_WB: begin
          if (snp_valid) begin
            if (s_flush && sidx == ridx) fsm <= F_REQ;
          end else if (bus_gnt) begin
            st[ridx] <= ST_I;
            fsm      <= F_REQ;
          end
        end
        F_REQ: begin
          if (snp_valid) begin
            if (s_kill && sidx == ridx && stag == rtag && cmd == C_UPG) cmd <= C_RDX;
          end else if (bus_gnt) begin
            tg[ridx] <= rtag;
            fsm      <= F_IDLE;
            cpu_done <= 1'b1;
            if (cmd == C_RD) begin
              st[ridx]  <= ST_S;
              dt[ridx]  <= bus_rdata;
              cpu_rdata <= bus_rdata;
            end else begin
              st[ridx]  <= ST_M;
              dt[ridx]  <= rwd;
              cpu_rdata <= rwd;
            end
          end
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  AST_SNOOP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> snp_ack); // R13
  AST_DIRTY_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_IDLE && cpu_req && cpu_we && go && c_hit && st[cidx] == ST_M) |=> !bus_req); // R5
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == C_WB && bus_gnt && go) |=> (bus_req && bus_cmd != C_WB)); // R11
  AST_UPGRADE_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_REQ && cmd == C_UPG && bus_gnt && go) |=> (st[ridx] == ST_M)); // R4
  AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    s_kill |=> (st[$past(sidx)] == ST_I)); // R8
  AST_UPGRADE_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_REQ && cmd == C_UPG && s_kill && sidx == ridx && stag == rtag) |=> (bus_req && bus_cmd == C_RDX)); // R12
endmodule

// File: tb/msi_line_ctrl_test.sv
`timescale 1ns/1ps
module msi_line_ctrl_test;
  localparam int LINES = 4, TAG_W = 4, DATA_W = 16, AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, snp_valid = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [15:0] cpu_wdata = '0, bus_rdata = '0;
  logic [1:0] snp_cmd = '0;
  logic cpu_done, bus_req, snp_ack, snp_flush;
  logic [15:0] cpu_rdata, bus_wdata, snp_fdata;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;

  msi_line_ctrl #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
    .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_ack(snp_ack), .snp_flush(snp_flush), .snp_fdata(snp_fdata));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;

  typedef struct packed {
    logic [1:0] op; logic [1:0] sc; logic [5:0] a; logic [15:0] wd;
    logic [1:0] nb; logic [1:0] c0; logic [1:0] c1; logic [5:0] a0;
    logic [15:0] wbd; logic [15:0] ex; logic fl;
  } vec_t;

  localparam vec_t VEC [20] = '{
    '{2'd0, 2'd0, 6'h04, 16'h0000, 2'd1, 2'd0, 2'd0, 6'h04, 16'h0000, 16'h5004, 1'b0},
    '{2'd0, 2'd0, 6'h04, 16'h0000, 2'd0, 2'd0, 2'd0, 6'h00, 16'h0000, 16'h5004, 1'b0},
    '{2'd1, 2'd0, 6'h04, 16'h1111, 2'd1, 2'd2, 2'd0, 6'h04, 16'h0000, 16'h1111, 1'b0},
    '{2'd1, 2'd0, 6'h04, 16'h2222, 2'd0, 2'd0, 2'd0, 6'h00, 16'h0000, 16'h2222, 1'b0},
    '{2'd2, 2'd0, 6'h04, 16'h0000, 2'd0, 2'd0, 2'd0, 6'h00, 16'h0000, 16'h2222, 1'b1},
    '{2'd2, 2'd0, 6'h04, 16'h0000, 2'd0, 2'd0, 2'd0, 6'h00, 16'h0000, 16'h0000, 1'b0},
    '{2'd0, 2'd0, 6'h04, 16'h0000, 2'd0, 2'd0, 2'd0, 6'h00, 16'h0000, 16'h2222, 1'b0},
    '{2'd2, 2'd1, 6'h04, 16'h0000, 2'd0, 2'd0, 2'd0, 6'h00, 16'h0000, 16'h0000, 1'b0},
    '{2'd0, 2'd0, 6'h04, 16'h0000, 2'd1, 2'd0, 2'd0, 6'h04, 16'h0000, 16'h5004, 1'b0},
    '{2'd1, 2'd0, 6'h09, 16'h3333, 2'd1, 2'd1, 2'd0, 6'h09, 16'h0000, 16'h3333, 1'b0},
    '{2'd2, 2'd1, 6'h09, 16'h0000, 2'd0, 2'd0, 2'd0, 6'h00, 16'h0000, 16'h3333, 1'b1},
    '{2'd0, 2'd0, 6'h09, 16'h0000, 2'd1, 2'd0, 2'd0, 6'h09, 16'h0000, 16'h5009, 1'b0},
    '{2'd1, 2'd0, 6'h0D, 16'h4444, 2'd1, 2'd1, 2'd0, 6'h0D, 16'h0000, 16'h4444, 1'b0},
    '{2'd0, 2'd0, 6'h11, 16'h0000, 2'd2, 2'd3, 2'd0, 6'h0D, 16'h4444, 16'h5011, 1'b0},
    '{2'd2, 2'd0, 6'h12, 16'h0000, 2'd0, 2'd0, 2'd0, 6'h00, 16'h0000, 16'h0000, 1'b0},
    '{2'd2, 2'd3, 6'h11, 16'h0000, 2'd0, 2'd0, 2'd0, 6'h00, 16'h0000, 16'h0000, 1'b0},
    '{2'd0, 2'd0, 6'h11, 16'h0000, 2'd0, 2'd0, 2'd0, 6'h00, 16'h0000, 16'h5011, 1'b0},
    '{2'd1, 2'd0, 6'h11, 16'h5555, 2'd1, 2'd2, 2'd0, 6'h11, 16'h0000, 16'h5555, 1'b0},
    '{2'd2, 2'd2, 6'h09, 16'h0000, 2'd0, 2'd0, 2'd0, 6'h00, 16'h0000, 16'h0000, 1'b0},
    '{2'd0, 2'd0, 6'h11, 16'h0000, 2'd0, 2'd0, 2'd0, 6'h00, 16'h0000, 16'h5555, 1'b0}
  };

  function automatic string vreq(input int i);
    case (i)
      0: return "R1";  1: return "R2";  2: return "R4";  3: return "R5";
      4: return "R6";  5, 6: return "R7"; 7, 8: return "R8";
      9: return "R3";  10, 11: return "R9"; 12, 13: return "R11";
      17: return "R4";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] mv(input logic [5:0] a);
    return 16'h5000 | {10'd0, a};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int seen_n;
  logic [1:0] seen_c [2];
  logic [5:0] seen_a0;
  logic [15:0] seen_wbd, got_rd, got_fd;
  logic got_ack, got_fl;

  task automatic cpu_op(input logic we, input logic [5:0] a, input logic [15:0] wd);
    seen_n = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    forever begin
      @(negedge clk);
      bus_gnt = 0;
      if (cpu_done) begin
        got_rd = cpu_rdata;
        cpu_req = 0;
        break;
      end
      if (bus_req) begin
        if (seen_n < 2) seen_c[seen_n] = bus_cmd;
        if (seen_n == 0) begin seen_a0 = bus_addr; seen_wbd = bus_wdata; end
        seen_n++;
        bus_gnt = 1;
        bus_rdata = mv(bus_addr);
      end
    end
  endtask

  task automatic snoop(input logic [1:0] sc, input logic [5:0] a);
    @(negedge clk);
    snp_valid = 1; snp_cmd = sc; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    got_ack = snp_ack; got_fl = snp_flush; got_fd = snp_fdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "cpu_done after reset", cpu_done, 0);
    check("R1", "bus_req after reset", bus_req, 0);
    check("R1", "snp_ack after reset", snp_ack, 0);

    for (int i = 0; i < 20; i++) begin
      vec_t v;
      v = VEC[i];
      if (v.op == 2'd2) begin
        snoop(v.sc, v.a);
        check("R13", "snoop ack", got_ack, 1);
        check(vreq(i), "snoop flush", got_fl, v.fl);
        if (v.fl) check(vreq(i), "flush data", got_fd, v.ex);
      end else begin
        cpu_op(v.op[0], v.a, v.wd);
        check(vreq(i), "bus transaction count", seen_n, v.nb);
        if (v.nb > 0) begin
          check(vreq(i), "first bus cmd", seen_c[0], v.c0);
          check(vreq(i), "first bus addr", seen_a0, v.a0);
        end
        if (v.nb > 1) begin
          check(vreq(i), "second bus cmd", seen_c[1], v.c1);
          check(vreq(i), "write-back data", seen_wbd, v.wbd);
        end
        check(vreq(i), "cpu rdata", got_rd, v.ex);
      end
    end

    // R12: snoop invalidates a line whose upgrade waits for the bus
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 6'h04; cpu_wdata = 16'h6666;
    for (int k = 0; k < 10 && !bus_req; k++) @(negedge clk);
    check("R12", "pending cmd is upgrade", bus_cmd, 2);
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 6'h04;
    @(negedge clk);
    snp_valid = 0;
    check("R13", "snoop ack while pending", snp_ack, 1);
    check("R12", "no flush of clean line", snp_flush, 0);
    check("R12", "request still pending", bus_req, 1);
    check("R12", "upgrade turned to read-for-ownership", bus_cmd, 1);
    bus_gnt = 1; bus_rdata = mv(6'h04);
    @(negedge clk);
    bus_gnt = 0;
    check("R12", "done after grant", cpu_done, 1);
    check("R12", "write data kept", cpu_rdata, 16'h6666);
    cpu_req = 0;
    snoop(2'd0, 6'h04);
    check("R12", "line owned after retried write", got_fl, 1);
    check("R6", "flushed data after retry", got_fd, 16'h6666);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule